// File: doc/BRIEF.md
# Oversampled UART Receiver with Majority Voting

This block receives 8N1 asynchronous serial frames on a single receive line. A baud-rate generator elsewhere supplies a one-cycle oversampling tick. The block samples the line once per tick. In normal mode a bit lasts 16 ticks. In double-speed mode it lasts 8 ticks, and the `dbl_speed` input selects which mode applies. The line passes through a two-flop synchronizer before any edge detection or sampling.

A frame begins at a high-to-low transition on a line that was seen high. The block confirms the start bit with a two-of-three vote over three samples near the middle of the bit. If the vote fails, it treats the pulse as noise and goes back to looking for an edge. The same vote decides each data bit and the stop bit. The timing is realigned on every start bit.

A received byte enters a two-entry FIFO together with a frame-error flag. The `rx_cmplt` output stays high while unread bytes remain, and each `rd_en` pulse removes the oldest byte. Dropping `rx_en` stops reception at once, discards the FIFO contents and abandons any frame in progress.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, and whenever `rx_en` is low, `rx_cmplt` and `overrun` are 0.
- R2: A start is detected on a tick whose synchronized sample is low when the previous tick's sample was high. That low sample counts as sample 1. With `dbl_speed`=0 a bit lasts 16 ticks and the vote samples are numbers 8, 9 and 10 of each bit. No state advances on a clock without a tick.
- R3: With `dbl_speed`=1 a bit lasts 8 ticks and the vote samples are numbers 4, 5 and 6 of each bit.
- R4: If at least two of the three start vote samples are high, the start is rejected. No byte is delivered, and the receiver waits for the next high-to-low edge.
- R5: Each of the 8 data bits is the majority of its three vote samples, and the first data bit received is bit 0 of `rd_data`. A wrong value on any single sample of a bit does not change the received value.
- R6: If the stop bit votes low, the byte is still stored and `rd_ferr`=1 is delivered with it. A new start then requires the line to be sampled high first, so a line that stays low produces no further bytes.
- R7: The FIFO holds 2 bytes. `rx_cmplt` is 1 while at least one byte is unread. `rd_data`/`rd_ferr` show the oldest byte, and a one-cycle `rd_en` removes it.
- R8: A byte completed while the FIFO is full, with no read in that cycle, is discarded and sets `overrun`. The flag stays set until the next read that removes a byte.
- R9: Driving `rx_en` low empties the FIFO, clears `overrun` and abandons the current frame on the next clock edge. A frame cut short in this way never delivers a byte.
- R10: Timing is realigned on every start bit, so frames separated by any idle gap of at least one sample are each received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes and idles the block |
| dbl_speed | input | 1 | 0: 16 samples per bit, 1: 8 samples per bit |
| os_tick | input | 1 | One-cycle oversampling strobe |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_en | input | 1 | Read strobe, removes the oldest byte |
| rd_data | output | 8 | Oldest unread byte |
| rd_ferr | output | 1 | Frame-error flag of the oldest byte |
| rx_cmplt | output | 1 | High while unread data is present |
| overrun | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |

## Verification
The hardest situations to reach from the ports are the ones where the receiver must refuse to act. A start pulse that is low only on the first vote sample must be rejected. A line held low after a failed stop bit must not be taken as a new frame. The bench drives the line one sample per tick, so it can place glitches on exact sample numbers: it flips one sample inside each vote window and at the bit edges, and it makes start pulses that are low for exactly 8 (or 4) samples. Disable and overrun are reached by holding the read monitor off while frames pile up, then cutting a frame in half with `rx_en`.

// File: rtl/uart_os_rx_pkg.sv
// Shared types for the oversampled receiver.
package uart_os_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchronizer for the asynchronous serial input.
// Assumes an idle-high line, so every stage resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_core.sv
// Frame recovery: detects the start edge, votes on three mid-bit samples
// of each bit and emits one push pulse per completed frame.
// Assumes tick is a single-cycle strobe and that dbl changes only while idle.
module rx_core
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_NORM = 16,
    parameter int OS_DBL  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dbl,
    input  logic              tick,
    input  logic              rxd_s,
    output logic              push,
    output logic [DATA_W-1:0] pdata,
    output logic              pferr
);
    localparam int CW = $clog2(OS_NORM + 1);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     idx;
    logic [CW-1:0]     nsmp;
    logic [CW-1:0]     vpos;
    logic [BW-1:0]     bitn;
    logic [DATA_W-1:0] shreg;
    logic              prev_s;
    logic              v1, v2;
    logic              voted;

    // Select the samples per bit and the first vote position for the mode.
    always_comb begin
        nsmp  = dbl ? CW'(OS_DBL) : CW'(OS_NORM);
        vpos  = nsmp >> 1;
        idx   = (cnt == nsmp) ? CW'(1) : cnt + CW'(1);
        voted = (v1 & v2) | (v1 & rxd_s) | (v2 & rxd_s);
    end

    // Sequencer: edge hunt, sample counting, voting and frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            prev_s <= 1'b0;
            v1     <= 1'b1;
            v2     <= 1'b1;
            push   <= 1'b0;
            pdata  <= '0;
            pferr  <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                prev_s <= rxd_s;
                if (state == ST_IDLE) begin
                    if (prev_s && !rxd_s) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                    end
                end else begin
                    cnt <= idx;
                    if (idx == vpos)          v1 <= rxd_s;
                    if (idx == vpos + CW'(1)) v2 <= rxd_s;
                    if (idx == vpos + CW'(2)) begin
                        case (state)
                            ST_START: if (voted) state <= ST_IDLE;
                            ST_DATA:  shreg <= {voted, shreg[DATA_W-1:1]};
                            ST_STOP: begin
                                push  <= 1'b1;
                                pdata <= shreg;
                                pferr <= ~voted;
                                state <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end else if (idx == nsmp) begin
                        if (state == ST_START) begin
                            state <= ST_DATA;
                            bitn  <= '0;
                        end else if (state == ST_DATA) begin
                            if (bitn == BW'(DATA_W - 1)) state <= ST_STOP;
                            else                         bitn  <= bitn + BW'(1);
                        end
                    end
                end
            end
        end
    end

    // R9: a low enable leaves the sequencer idle with no delivery.
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE) && !push);

    // R2: without a tick neither the state nor the sample count moves.
    p_no_tick_no_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> ($stable(state) && $stable(cnt)));

    // R6: a delivery only ever follows the stop-bit phase.
    p_push_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(state) == ST_STOP));
endmodule

// File: rtl/rx_fifo.sv
// Small receive FIFO with first-word-fall-through output and a sticky
// overrun flag. Assumes DEPTH is a power of two.
module rx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rdata,
    output logic             not_empty,
    output logic             overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp, rp;
    logic [AW:0]      fill;
    logic             full, pop, accept;

    // Occupancy and handshake decode.
    always_comb begin
        fill      = wp - rp;
        full      = (fill == (AW+1)'(DEPTH));
        not_empty = (fill != '0);
        pop       = rd_en && not_empty;
        accept    = push && (!full || pop);
        rdata     = mem[rp[AW-1:0]];
    end

    // Storage writes.
    always_ff @(posedge clk) begin
        if (accept) mem[wp[AW-1:0]] <= wdata;
    end

    // Pointer and overrun flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp      <= '0;
            rp      <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wp <= wp + 1'b1;
            if (pop)    rp <= rp + 1'b1;
            if (push && !accept) overrun <= 1'b1;
            else if (pop)        overrun <= 1'b0;
        end
    end

    // R7: unread data stays flagged until it is read or flushed.
    p_pending_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && !rd_en && !flush) |=> not_empty);

    // R8: overrun stays set until a read or a flush.
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_en && !flush) |=> overrun);

    // R9: a flush leaves the buffer empty and the flag clear.
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!not_empty && !overrun));
endmodule

// File: rtl/uart_os_rx.sv
// Top level: synchronizer, frame recovery and receive FIFO.
// Assumes os_tick comes from an external baud generator at 16x or 8x.
module uart_os_rx #(
    parameter int DATA_W     = 8,
    parameter int OS_NORM    = 16,
    parameter int OS_DBL     = 8,
    parameter int FIFO_DEPTH = 2,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              dbl_speed,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ferr,
    output logic              rx_cmplt,
    output logic              overrun
);
    logic              rxd_s;
    logic              push;
    logic [DATA_W-1:0] pdata;
    logic              pferr;
    logic [DATA_W:0]   head;

    rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_core #(.DATA_W(DATA_W), .OS_NORM(OS_NORM), .OS_DBL(OS_DBL)) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (rx_en),
        .dbl  (dbl_speed),
        .tick (os_tick),
        .rxd_s(rxd_s),
        .push (push),
        .pdata(pdata),
        .pferr(pferr)
    );

    rx_fifo #(.WIDTH(DATA_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!rx_en),
        .push     (push),
        .wdata    ({pferr, pdata}),
        .rd_en    (rd_en),
        .rdata    (head),
        .not_empty(rx_cmplt),
        .overrun  (overrun)
    );

    assign rd_ferr = head[DATA_W];
    assign rd_data = head[DATA_W-1:0];
endmodule

// File: tb/tb_uart_os_rx.sv
// Scoreboard bench: frame tasks queue expected bytes, a monitor drains the FIFO.
module tb_uart_os_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       dbl_speed = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ferr;
    logic       rx_cmplt;
    logic       overrun;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b1;
    logic [8:0] q_exp [$];
    string      q_tag [$];

    always #4 clk = ~clk;

    uart_os_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_speed(dbl_speed),
        .os_tick(os_tick), .rxd(rxd), .rd_en(rd_en), .rd_data(rd_data),
        .rd_ferr(rd_ferr), .rx_cmplt(rx_cmplt), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One oversampling period: set the line, then pulse the tick.
    task automatic smp(input logic b);
        rxd = b;
        repeat (3) @(negedge clk);
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop_v, input bit want,
                              input string tag, input bit flip, input int low_after,
                              input int gap);
        int n;
        int m;
        n = dbl_speed ? 8 : 16;
        m = n / 2;
        if (want) begin
            q_exp.push_back({~stop_v, d});
            q_tag.push_back(tag);
        end
        for (int s = 1; s <= n; s++) smp((flip && s == m + 1) ? 1'b1 : 1'b0);
        for (int i = 0; i < 8; i++)
            for (int s = 1; s <= n; s++)
                smp((flip && (s == 1 || s == m || s == n)) ? ~d[i] : d[i]);
        for (int s = 1; s <= n; s++) smp(stop_v);
        for (int s = 0; s < low_after; s++) smp(1'b0);
        for (int s = 0; s < gap; s++) smp(1'b1);
    endtask

    task automatic drain;
        int t;
        t = 0;
        while ((q_exp.size() != 0 || rx_cmplt) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    // Monitor: read each available byte and compare with the queue head.
    always @(negedge clk) begin
        if (rd_en) rd_en <= 1'b0;
        else if (mon_on && rx_cmplt) begin
            if (q_exp.size() == 0)
                chk(1'b0, "R7 unexpected byte", {rd_ferr, rd_data}, 0);
            else begin
                chk({rd_ferr, rd_data} == q_exp[0], q_tag[0], {rd_ferr, rd_data}, q_exp[0]);
                void'(q_exp.pop_front());
                void'(q_tag.pop_front());
            end
            rd_en <= 1'b1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_cmplt, "R1 reset cmplt", rx_cmplt, 0);
        chk(!overrun, "R1 reset overrun", overrun, 0);
        rx_en = 1'b1;
        for (int i = 0; i < 3; i++) smp(1'b1);

        // R2 / R5: normal mode frames, clean and with flipped samples.
        send_frame(8'hA5, 1'b1, 1, "R2 normal A5", 0, 0, 2);
        send_frame(8'h3C, 1'b1, 1, "R5 noisy 3C", 1, 0, 1);
        // R10: back-to-back with one idle sample, then a long gap.
        send_frame(8'h81, 1'b1, 1, "R10 gap1 81", 0, 0, 1);
        send_frame(8'h7E, 1'b1, 1, "R10 gap 7E", 0, 0, 23);
        drain();

        // R4: start pulse low only on samples 1..8 is a spike.
        for (int s = 0; s < 8; s++) smp(1'b0);
        for (int s = 0; s < 12; s++) smp(1'b1);
        chk(!rx_cmplt, "R4 spike 16x", rx_cmplt, 0);
        send_frame(8'h5A, 1'b1, 1, "R4 after spike", 0, 0, 2);
        drain();

        // R6: frame error, line stays low afterwards.
        send_frame(8'hC3, 1'b0, 1, "R6 ferr C3", 0, 30, 3);
        send_frame(8'h12, 1'b1, 1, "R6 after ferr", 0, 0, 2);
        drain();

        // R3: double-speed mode.
        dbl_speed = 1'b1;
        send_frame(8'h96, 1'b1, 1, "R3 dbl 96", 0, 0, 2);
        send_frame(8'h0F, 1'b1, 1, "R3 dbl noisy 0F", 1, 0, 1);
        for (int s = 0; s < 4; s++) smp(1'b0);
        for (int s = 0; s < 8; s++) smp(1'b1);
        chk(!rx_cmplt, "R4 spike 8x", rx_cmplt, 0);
        send_frame(8'hE7, 1'b0, 1, "R3 dbl ferr E7", 0, 0, 2);
        drain();
        dbl_speed = 1'b0;

        // R8: three frames with no reads; third is dropped.
        mon_on = 1'b0;
        send_frame(8'h11, 1'b1, 1, "R8 first", 0, 0, 2);
        send_frame(8'h22, 1'b1, 1, "R8 second", 0, 0, 2);
        chk(!overrun, "R8 no overrun at two", overrun, 0);
        send_frame(8'h33, 1'b1, 0, "", 0, 0, 2);
        chk(overrun, "R8 overrun set", overrun, 1);
        chk(rx_cmplt, "R7 cmplt with full fifo", rx_cmplt, 1);
        repeat (20) @(negedge clk);
        chk(overrun, "R8 overrun sticky", overrun, 1);
        mon_on = 1'b1;
        drain();
        chk(!overrun, "R8 overrun cleared by read", overrun, 0);
        chk(!rx_cmplt, "R7 empty after drain", rx_cmplt, 0);

        // R9: buffered byte plus half a frame, then disable.
        mon_on = 1'b0;
        send_frame(8'h44, 1'b1, 0, "", 0, 0, 2);
        for (int s = 0; s < 16 * 4; s++) smp((s >= 16 && s < 40) ? 1'b1 : 1'b0);
        chk(rx_cmplt, "R9 byte buffered", rx_cmplt, 1);
        rx_en = 1'b0;
        @(negedge clk);
        chk(!rx_cmplt, "R9 flushed", rx_cmplt, 0);
        for (int s = 0; s < 100; s++) smp(1'b0);
        chk(!rx_cmplt, "R1 off stays empty", rx_cmplt, 0);
        chk(!overrun, "R1 off no overrun", overrun, 0);
        rx_en = 1'b1;
        mon_on = 1'b1;
        for (int s = 0; s < 4; s++) smp(1'b1);
        send_frame(8'h69, 1'b1, 1, "R9 after re-enable", 0, 0, 2);
        drain();

        chk(q_exp.size() == 0, "R10 all frames delivered", q_exp.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule